// File: doc/BRIEF.md
# Three-Stage Programmable Clock Divider Chain

This block models the divider chain that surrounds a frequency synthesiser: an input (reference) divider, a feedback-path divider and an output divider. The oscillator itself is out of scope, so all three dividers run from the same input clock. Each divider drives its own output clock. Software programs each stage through a 32-bit control word that sets separate high-phase and low-phase counts. The output period is their sum. An edge-select bit adds half an input period to the high phase, which brings an odd ratio close to 50% duty. A bypass bit sends the input clock straight through.

A write can be marked as held. It is then only parked in that stage's shadow register. The next write that is not held moves every shadow word into the live settings in one step and restarts all three counters. After each such step a lock flag reads 0 for a fixed settle window, then returns to 1. Software polls this flag before it relies on the new clocks.

Top module: `clkdiv_chain`

## Requirements
- R1: A control word carries the low count in bits 5:0, the high count in bits 11:6, the edge bit in bit 12, the bypass bit in bit 13 and the hold (no-update) bit in bit 14. The stage words sit at byte addresses 0x0, 0x4 and 0x8 for stages 0, 1 and 2. A read of a stage address returns bits 14:0 of the last word written there, and bits 31:15 read as zero.
- R2: With bypass clear and both counts non-zero, a stage's output period is exactly low+high input cycles, for every ratio up to 126.
- R3: With the edge bit 0, the output is high for `high` whole input cycles in each period and low for `low` whole cycles.
- R4: With the edge bit 1, the high phase lasts high+0.5 input cycles and the low phase lasts low-0.5 cycles, because a falling-edge register extends the high phase.
- R5: With the bypass bit set, the stage output equals the input clock, whatever the counts are.
- R6: A low or high count of zero with bypass clear behaves as bypass, so the output never stops.
- R7: A write with the hold bit set changes only the read-back value. The live stage outputs and the lock flag stay as they were.
- R8: A write with the hold bit clear makes the written word and the held words of all other stages live at the same clock edge. A stage that was never rewritten keeps its previous live setting.
- R9: The lock flag is bit 0 of the word at byte address 0xC. It is 1 after reset. After each applying write it reads 0 for exactly 16 input-clock cycles, then 1.
- R10: After reset every stage word reads 0, and so every stage passes the input clock (per R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; also clocks the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| addr | input | 4 | Byte address of the register being read or written |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| stage_clk | output | 3 | Divided clocks; bit k belongs to stage k |

## Verification
The assertions assume that `wr_en` and `addr` are steady around the rising edge, and that a new applying write may land while the flag is still low, which only lengthens the low window. The settle-length property therefore checks a lower bound. The bench drives the port at the falling edge and holds each strobe for one cycle. It measures the clocks only after the flag is back at 1, so the counter restart that follows an update stays outside every window. Duty and period are found by sampling each output a quarter-period after both input edges over whole output periods, which makes the counts independent of phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CNT_W      = 6;
  localparam int NUM_STAGES = 3;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 4;
  localparam int CFG_W      = 2 * CNT_W + 3;
  localparam logic [ADDR_W-1:0] LOCK_ADDR = 4'hC;

  // Control word layout, MSB first: hold, pass, half, hi_cnt, lo_cnt
  typedef struct packed {
    logic             hold;
    logic             pass;
    logic             half;
    logic [CNT_W-1:0] hi_cnt;
    logic [CNT_W-1:0] lo_cnt;
  } stage_cfg_t;

  function automatic logic eff_bypass(stage_cfg_t c);
    return c.pass || (c.hi_cnt == '0) || (c.lo_cnt == '0);
  endfunction

  function automatic logic [CNT_W:0] stage_ratio(stage_cfg_t c);
    return {1'b0, c.hi_cnt} + {1'b0, c.lo_cnt};
  endfunction

  function automatic logic [ADDR_W-1:0] stage_addr(int k);
    return ADDR_W'(k * 4);
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [CFG_W-1:0]                   wcfg,
  output stage_cfg_t [NUM_STAGES-1:0]        pend_q,
  output stage_cfg_t [NUM_STAGES-1:0]        live_q,
  output logic                               apply_evt
);
  logic [NUM_STAGES-1:0] hit;
  stage_cfg_t            wr_cfg;

  assign wr_cfg = stage_cfg_t'(wcfg);

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_hit
    assign hit[g] = wr_en && (addr == stage_addr(g));
  end

  assign apply_evt = (|hit) && !wr_cfg.hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      live_q <= '0;
    end else begin
      for (int k = 0; k < NUM_STAGES; k++) begin
        if (hit[k]) pend_q[k] <= wr_cfg;
        if (apply_evt) live_q[k] <= hit[k] ? wr_cfg : pend_q[k];
      end
    end
  end

  // R7: without an applying write the live settings never move
  p_hold_keeps_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_evt |=> $stable(live_q));

  // R8: right after an apply every live word equals its shadow word
  p_apply_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    apply_evt |=> (live_q == pend_q));
endmodule

// File: rtl/clkdiv_lock.sv
module clkdiv_lock #(
  parameter int SETTLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic apply,
  output logic locked
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] remain_q;
  logic [CW:0]   low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain_q <= '0;
    else if (apply)           remain_q <= CW'(SETTLE);
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign locked = (remain_q == '0);

  // length of the current low run, for the settle check below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_run_q <= '0;
    else if (locked)            low_run_q <= '0;
    else if (low_run_q != '1)   low_run_q <= low_run_q + 1'b1;
  end

  // R9: lock drops on the cycle after an apply
  p_lock_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !locked);

  // R9: lock never returns before the settle window has elapsed
  p_settle_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (low_run_q >= (CW+1)'(SETTLE)));
endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage
  import clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  stage_cfg_t cfg,
  output logic       clk_o
);
  logic [CNT_W:0] cnt_q;
  logic [CNT_W:0] cnt_nxt;
  logic [CNT_W:0] ratio_w;
  logic           byp;
  logic           last;
  logic           q_rise;
  logic           q_fall;

  assign ratio_w = stage_ratio(cfg);
  assign byp     = eff_bypass(cfg);
  assign last    = (cnt_q == ratio_w - 1'b1);
  assign cnt_nxt = last ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      q_rise <= 1'b0;
    end else if (restart || byp) begin
      cnt_q  <= '0;
      q_rise <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      q_rise <= (cnt_nxt < {1'b0, cfg.hi_cnt});
    end
  end

  // falling-edge copy stretches the high phase by half a period
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_fall <= 1'b0;
    else        q_fall <= q_rise && cfg.half && !byp;
  end

  assign clk_o = byp ? clk : (q_rise | q_fall);

  // R2: counter stays inside one output period
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !byp |-> (cnt_q < ratio_w));

  // R2: period wraps after ratio cycles
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp && !restart && last) |=> (cnt_q == '0));

  // R6: a bypassed stage leaves its divided phase idle
  p_bypass_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byp |=> !q_rise);
endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
  import clkdiv_pkg::*;
#(
  parameter int SETTLE = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     wdata,
  output logic [WORD_W-1:0]     rdata,
  output logic [NUM_STAGES-1:0] stage_clk
);
  stage_cfg_t [NUM_STAGES-1:0] pend;
  stage_cfg_t [NUM_STAGES-1:0] live;
  logic                        apply_evt;
  logic                        locked;
  logic                        unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[WORD_W-1:CFG_W];

  clkdiv_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wcfg      (wdata[CFG_W-1:0]),
    .pend_q    (pend),
    .live_q    (live),
    .apply_evt (apply_evt)
  );

  clkdiv_lock #(.SETTLE(SETTLE)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .apply  (apply_evt),
    .locked (locked)
  );

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    clkdiv_stage u_stg (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (apply_evt),
      .cfg     (live[g]),
      .clk_o   (stage_clk[g])
    );
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_STAGES; k++) begin
      if (addr == stage_addr(k)) rdata = {{(WORD_W-CFG_W){1'b0}}, pend[k]};
    end
    if (addr == LOCK_ADDR) rdata = {{(WORD_W-1){1'b0}}, locked};
  end

  // R1: reserved read bits are always zero
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[WORD_W-1:CFG_W] == '0);
endmodule

// File: tb/sim_clkdiv_chain.sv
`timescale 1ns/10ps
module sim_clkdiv_chain;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  stage_clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit mon_busy = 0;

  typedef struct {
    int    stg;
    int    win;
    int    exp_hi;
    int    exp_rise;
    string req;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  clkdiv_chain u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .stage_clk(stage_clk)
  );

  localparam logic [31:0] HOLD = 32'h4000;

  function automatic logic [31:0] mk(int lo, int hi, int half, int pass, int hold);
    return (32'(hold) << 14) | (32'(pass) << 13) | (32'(half) << 12) |
           (32'(hi) << 6) | 32'(lo);
  endfunction

  // ratio N as a control word: even splits evenly, odd gives low the extra cycle
  function automatic logic [31:0] enc(int n);
    if (n == 1) return mk(0, 0, 0, 1, 0);
    return mk(n - n / 2, n / 2, n % 2, 0, 0);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a;
    #0.1 d = rdata;
  endtask

  // call right after an applying write: count low samples of the lock flag
  task automatic lock_after_apply(string req);
    logic [31:0] d;
    int lows = 0;
    rd(4'hC, d);
    while (d[0] == 1'b0 && lows < 100) begin
      lows++;
      @(posedge clk); #1;
      rd(4'hC, d);
    end
    check(req, lows, 16);
  endtask

  task automatic push(int stg, int lo, int hi, int half, int pass, string req);
    exp_t e;
    e.stg = stg; e.req = req;
    if (pass != 0 || lo == 0 || hi == 0) begin
      e.win = 4; e.exp_hi = 4; e.exp_rise = 4;
    end else begin
      e.win = 2 * (lo + hi);
      e.exp_hi = 2 * (2 * hi + half);
      e.exp_rise = 2;
    end
    sb_q.push_back(e);
  endtask

  task automatic drain();
    #1;
    wait (sb_q.size() == 0 && !mon_busy);
  endtask

  // monitor: pops expected items and measures the named stage clock
  initial begin
    forever begin
      exp_t e;
      int highs;
      int rises;
      logic prev;
      logic s;
      wait (sb_q.size() > 0);
      mon_busy = 1;
      e = sb_q.pop_front();
      highs = 0; rises = 0;
      @(posedge clk); #1.25 prev = stage_clk[e.stg];
      for (int i = 0; i < e.win; i++) begin
        @(negedge clk); #1.25 s = stage_clk[e.stg];
        highs += int'(s); if (s && !prev) rises++; prev = s;
        @(posedge clk); #1.25 s = stage_clk[e.stg];
        highs += int'(s); if (s && !prev) rises++; prev = s;
      end
      check({e.req, " high half-cycles"}, highs, e.exp_hi);
      check({e.req, " periods"}, rises, e.exp_rise);
      mon_busy = 0;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;

    // R10 / R9: reset state
    for (int k = 0; k < 3; k++) begin
      rd(4'(k * 4), d);
      check("R10 reset word", int'(d), 0);
    end
    rd(4'hC, d);
    check("R9 lock after reset", int'(d), 1);
    for (int k = 0; k < 3; k++) push(k, 0, 0, 0, 0, "R10 reset pass-through");
    drain();

    // R7: held writes change read-back only
    wr(4'h0, enc(4) | HOLD);
    wr(4'h4, enc(5) | HOLD);
    rd(4'h0, d);
    check("R1 readback held word", int'(d), int'(enc(4) | HOLD));
    begin
      int lowseen = 0;
      for (int i = 0; i < 20; i++) begin
        rd(4'hC, d);
        if (d[0] == 1'b0) lowseen++;
        @(posedge clk); #1;
      end
      check("R7 lock stays high on held write", lowseen, 0);
    end
    push(0, 0, 0, 0, 0, "R7 held stage0 still bypassed");
    drain();

    // R8: one applying write releases all held words
    wr(4'h8, enc(7));
    lock_after_apply("R9 settle after apply");
    push(0, 2, 2, 0, 0, "R3 even ratio 4");
    push(1, 3, 2, 1, 0, "R4 odd ratio 5 edge mode");
    push(2, 4, 3, 1, 0, "R8 applying stage ratio 7");
    drain();

    // R1: reserved bits discarded, hold bit kept in read-back
    wr(4'h4, 32'hFFFF_C000 | enc(3));
    rd(4'h4, d);
    check("R1 reserved bits read zero", int'(d), int'(enc(3) | HOLD));
    rd(4'hC, d);
    check("R7 lock high after held write", int'(d), 1);

    // R5: bypass bit wins over counts
    wr(4'h0, mk(5, 5, 0, 1, 0));
    lock_after_apply("R9 settle after second apply");
    push(0, 5, 5, 0, 1, "R5 bypass bit");
    push(1, 2, 1, 1, 0, "R4 odd ratio 3 edge mode");
    push(2, 4, 3, 1, 0, "R8 untouched stage keeps setting");
    drain();

    // R6: zero counts behave as bypass
    wr(4'h8, mk(0, 4, 0, 0, 0));
    lock_after_apply("R9 settle after third apply");
    push(2, 0, 4, 0, 0, "R6 zero low count");
    drain();
    wr(4'h8, mk(5, 0, 1, 0, 0));
    lock_after_apply("R9 settle after fourth apply");
    push(2, 5, 0, 1, 0, "R6 zero high count");
    drain();

    // R3: odd ratio without edge bit, R2: largest ratio
    wr(4'h0, mk(3, 2, 0, 0, 0));
    lock_after_apply("R9 settle after fifth apply");
    push(0, 3, 2, 0, 0, "R3 odd ratio no edge");
    drain();
    wr(4'h4, enc(126));
    lock_after_apply("R9 settle after sixth apply");
    push(1, 63, 63, 0, 0, "R2 ratio 126");
    push(0, 3, 2, 0, 0, "R8 stage0 kept after stage1 apply");
    drain();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule